// File: doc/BRIEF.md
# SPI Flash Page-Program Write Buffer

This block collects one flash page worth of write data (128 bytes by default) through a single 32-bit push port into an internal buffer. It then sends that data to a serial flash as one page-program frame on a single-lane SPI master port. The frame is the program opcode, a 24-bit address and the buffered bytes. A byte-wide programmed-I/O path sends the same kind of frame carrying a single data byte. It is meant for the tail of a write that does not fill a whole page, and it steps the flash address forward after each byte.

The internal buffer is shared with a read-prefetch function. A mode bit hands it over to program use. The mode readback shows the new role only once the handover has taken effect, which is one clock later, or after any frame in flight has finished. Software loads the four address byte registers and pushes the page as 32 words. It then writes a command code and polls the command register until it reads zero.

Top module: `spi_page_writer`

## Requirements
- R1: After reset the command register (index 0), mode register (index 1) and status register (index 2) read 0, spi_cs_n is 1 and spi_sck is 0.
- R2: Writing bit 0 of the mode register (0 = prefetch, 1 = program) changes its readback one clock after the write edge when idle. While a frame is in flight the readback keeps its old value until the frame ends.
- R3: Each pushed word (push register, index 4) is sent little-endian: bits 7:0 go first and bits 31:24 go last, and words go out in push order.
- R4: Writing code 0x10 to the command register, in program mode with 32 words loaded, sends one frame with spi_cs_n low throughout. The frame is opcode 0x02, address bits 23:0 MSB first (address byte registers at indices 5, 6, 7, 8 hold bits 7:0, 15:8, 23:16, 31:24), then 128 data bytes. Every byte goes MSB first, 1056 clocks of spi_sck in all.
- R5: The command register reads the active code (0x10 or 0x90) while a frame is in flight and reads 0 once it is done.
- R6: Code 0x10 is refused in prefetch mode or with fewer than 32 words loaded. In that case no frame is sent, the command register stays 0 and the error flag (status bit 0) is set.
- R7: The push pointer returns to zero when a buffered frame completes and when the effective mode changes, so a new full page must be pushed before the next buffered start.
- R8: Pushes beyond the 32nd word are ignored and do not alter the buffered data.
- R9: Code 0x90 sends opcode 0x02, the 24-bit address MSB first and the byte from the write-byte register (index 3), 40 clocks in all. When it completes, the 32-bit address register is incremented by one, with carry into the upper bytes.
- R10: The error flag is sticky. Writing status with bit 0 at 1 clears it, and writing 0 leaves it.
- R11: SPI mode 0 is used. spi_mosi holds steady while spi_sck is high, spi_sck is low whenever spi_cs_n is high, and within a frame spi_sck rises every 2*HALF clocks.
- R12: While a frame is in flight, command, push, address and write-byte writes are ignored. A command code other than 0x10 and 0x90 is ignored at any time and leaves the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |

## Verification
Register readback is combinational, so a register write is visible at the next falling clock after its write edge. The exceptions are the effective mode, which is due one clock later, and the refusal error, which is set on the command write edge itself. The bench reads at falling clock edges and places the mode check on exactly the second falling edge. The serial frame is captured on rising spi_sck while chip select is low, so its checks do not depend on the exact start cycle. Completion is checked by polling the command register each falling edge until it reads zero, and the frame contents are compared only after that.

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
  parameter int WORDS = 32,
  parameter int HALF = 2,
  parameter logic [7:0] OPCODE = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi
);
  localparam int IW = $clog2(WORDS);
  localparam int PW = $clog2(WORDS + 1);
  localparam int NB_BUF = 32 + 32 * WORDS;
  localparam int NB_PIO = 40;
  localparam int BW = $clog2(NB_BUF);
  localparam int DW = $clog2(HALF);
  localparam logic [3:0] A_CMD = 4'd0, A_MODE = 4'd1, A_STAT = 4'd2, A_WBYTE = 4'd3,
                         A_PUSH = 4'd4, A_ADR0 = 4'd5, A_ADR3 = 4'd8;
  localparam logic [7:0] C_BUF = 8'h10, C_PIO = 8'h90;

  logic [31:0]   mem [WORDS];
  logic [PW-1:0] wptr;
  logic          mode_req, mode_act, err, busy, pio;
  logic [31:0]   addr;
  logic [7:0]    wbyte;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] div;

  wire wr_cmd = reg_we && reg_addr == A_CMD && !busy;
  wire go_buf = wr_cmd && reg_wdata[7:0] == C_BUF;
  wire ok_buf = go_buf && mode_act && wptr == PW'(WORDS);
  wire go_pio = wr_cmd && reg_wdata[7:0] == C_PIO;
  wire push   = reg_we && reg_addr == A_PUSH && !busy && mode_act && wptr != PW'(WORDS);
  wire swap   = !busy && mode_act != mode_req;
  wire tick   = busy && div == DW'(HALF - 1);
  wire last   = bitcnt == (pio ? BW'(NB_PIO - 1) : BW'(NB_BUF - 1));
  wire fin    = tick && spi_sck && last;

  logic [BW-4:0] bi, di;
  logic [7:0]    cur;
  logic [31:0]   word;
  assign bi = bitcnt[BW-1:3];
  assign di = bi - (BW-3)'(4);
  assign word = mem[IW'(di >> 2)];
  always_comb begin
    case (bi)
      '0:                 cur = OPCODE;
      (BW-3)'(1):         cur = addr[23:16];
      (BW-3)'(2):         cur = addr[15:8];
      (BW-3)'(3):         cur = addr[7:0];
      default:            cur = pio ? wbyte : word[{di[1:0], 3'b000} +: 8];
    endcase
  end

  assign spi_mosi = busy && cur[~bitcnt[2:0]];
  assign spi_cs_n = !busy;

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = busy ? {24'h0, pio ? C_PIO : C_BUF} : 32'h0;
      A_MODE:  reg_rdata = {31'h0, mode_act};
      A_STAT:  reg_rdata = {31'h0, err};
      A_WBYTE: reg_rdata = {24'h0, wbyte};
      4'd5:    reg_rdata = {24'h0, addr[7:0]};
      4'd6:    reg_rdata = {24'h0, addr[15:8]};
      4'd7:    reg_rdata = {24'h0, addr[23:16]};
      A_ADR3:  reg_rdata = {24'h0, addr[31:24]};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) if (push) mem[IW'(wptr)] <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; mode_req <= 1'b0; mode_act <= 1'b0; err <= 1'b0;
      addr <= '0; wbyte <= '0;
    end else begin
      if (reg_we && reg_addr == A_MODE) mode_req <= reg_wdata[0];
      if (!busy) mode_act <= mode_req;
      if (swap || (fin && !pio)) wptr <= '0;
      else if (push) wptr <= wptr + PW'(1);
      if (go_buf && !ok_buf) err <= 1'b1;
      else if (reg_we && reg_addr == A_STAT && reg_wdata[0]) err <= 1'b0;
      if (reg_we && !busy && reg_addr == A_WBYTE) wbyte <= reg_wdata[7:0];
      if (fin && pio) addr <= addr + 32'd1;
      else if (reg_we && !busy && reg_addr >= A_ADR0 && reg_addr <= A_ADR3)
        addr[{reg_addr[1:0] - 2'd1, 3'b000} +: 8] <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pio <= 1'b0; spi_sck <= 1'b0; bitcnt <= '0; div <= '0;
    end else if (ok_buf || go_pio) begin
      busy <= 1'b1; pio <= go_pio; spi_sck <= 1'b0; bitcnt <= '0; div <= '0;
    end else if (busy) begin
      div <= tick ? '0 : div + DW'(1);
      if (tick) begin
        spi_sck <= !spi_sck;
        if (spi_sck) begin
          if (last) busy <= 1'b0;
          else bitcnt <= bitcnt + BW'(1);
        end
      end
    end
  end

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ok_buf |=> busy && !spi_cs_n && !pio);
  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_buf && !ok_buf) |=> !busy && err);
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_act));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= PW'(WORDS));
  p_cs_sck_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_mosi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == A_WBYTE) |=> $stable(wbyte));
endmodule

// File: tb/test_spi_page_writer.sv
module test_spi_page_writer;
  localparam int HALF = 2;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;
  int total = 0, failed = 0;
  logic [7:0] capb [0:199];
  logic [7:0] expb [0:199];
  int nbits = 0, mviol = 0, pviol = 0;
  logic [31:0] words [0:31];
  logic [31:0] cur_addr;
  logic [31:0] rv;
  bit done = 0;

  always #5 clk = ~clk;

  spi_page_writer #(.HALF(HALF)) i_spi_page_writer (.*);

  always @(posedge spi_sck) if (!spi_cs_n) begin
    capb[nbits >> 3] = {capb[nbits >> 3][6:0], spi_mosi};
    nbits++;
  end

  logic prev_sck = 0, last_m = 0, seen = 0;
  int cyc = 0;
  always @(negedge clk) begin
    if (spi_sck && prev_sck && spi_mosi != last_m) mviol++;
    if (spi_cs_n && spi_sck) mviol++;
    cyc++;
    if (spi_cs_n) seen = 0;
    else if (spi_sck && !prev_sck) begin
      if (seen && cyc != 2 * HALF) pviol++;
      seen = 1; cyc = 0;
    end
    last_m = spi_mosi; prev_sck = spi_sck;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic set_addr(logic [31:0] a);
    for (int i = 0; i < 4; i++) wr(4'(5 + i), {24'h0, a[8*i +: 8]});
    cur_addr = a;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    rd(0, rv);
    while (rv != 0 && n < 20000) begin @(negedge clk); rd(0, rv); n++; end
    chk(rv == 0, req, "command clears when done", rv, 0);
  endtask

  function automatic void hdr(logic [31:0] a);
    expb[0] = 8'h02; expb[1] = a[23:16]; expb[2] = a[15:8]; expb[3] = a[7:0];
  endfunction

  task automatic check_frame(string req, int nbytes);
    int bad = 0, first = -1;
    chk(nbits == nbytes * 8, req, "frame bit count", nbits, nbytes * 8);
    for (int i = 0; i < nbytes; i++)
      if (capb[i] !== expb[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) first = 0;
    chk(bad == 0, req, $sformatf("frame bytes (first bad %0d)", first), capb[first], expb[first]);
  endtask

  task automatic load_page(bit extra);
    for (int w = 0; w < 32; w++) begin words[w] = $urandom; wr(4, words[w]); end
    if (extra) wr(4, 32'hDEADBEEF);
    hdr(cur_addr);
    for (int k = 0; k < 128; k++) expb[4 + k] = words[k / 4][8 * (k % 4) +: 8];
  endtask

  task automatic pio_byte(logic [7:0] b, string req);
    wr(3, {24'h0, b});
    hdr(cur_addr); expb[4] = b;
    nbits = 0;
    wr(0, 32'h90);
    rd(0, rv); chk(rv == 32'h90, "R5", "pio command busy readback", rv, 32'h90);
    wait_idle("R5");
    check_frame(req, 5);
    cur_addr = cur_addr + 1;
  endtask

  initial begin
    rv = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, rv); chk(rv == 0, "R1", "cmd after reset", rv, 0);
    rd(1, rv); chk(rv == 0, "R1", "mode after reset", rv, 0);
    rd(2, rv); chk(rv == 0, "R1", "status after reset", rv, 0);
    chk(spi_cs_n == 1 && spi_sck == 0, "R1", "cs_n/sck after reset", {spi_cs_n, spi_sck}, 2);

    nbits = 0;
    wr(0, 32'h10);
    rd(0, rv); chk(rv == 0, "R6", "refused in prefetch, cmd", rv, 0);
    rd(2, rv); chk(rv == 1, "R6", "refused in prefetch, err", rv, 1);
    repeat (10) @(negedge clk);
    chk(nbits == 0, "R6", "no frame when refused", nbits, 0);
    wr(2, 0); rd(2, rv); chk(rv == 1, "R10", "err sticky on write 0", rv, 1);
    wr(2, 1); rd(2, rv); chk(rv == 0, "R10", "err cleared by write 1", rv, 0);

    wr(1, 1);
    rd(1, rv); chk(rv == 0, "R2", "mode not yet switched", rv, 0);
    @(negedge clk);
    rd(1, rv); chk(rv == 1, "R2", "mode switched one clock later", rv, 1);

    for (int w = 0; w < 5; w++) wr(4, $urandom);
    wr(0, 32'h10);
    rd(2, rv); chk(rv == 1, "R6", "refused with partial page", rv, 1);
    wr(2, 1);
    wr(0, 32'h33);
    rd(0, rv); chk(rv == 0, "R12", "unknown code ignored", rv, 0);
    rd(2, rv); chk(rv == 0, "R12", "unknown code leaves err", rv, 0);

    // R7: mode toggle discards the partial page
    wr(1, 0); @(negedge clk); wr(1, 1); @(negedge clk);
    set_addr($urandom);
    load_page(1);
    wr(3, 32'h5A);
    nbits = 0;
    wr(0, 32'h10);
    rd(0, rv); chk(rv == 32'h10, "R5", "buffered command busy readback", rv, 32'h10);
    rd(2, rv); chk(rv == 0, "R7", "full page accepted after mode toggle", rv, 0);
    wr(0, 32'h90);
    wr(3, 32'hA5);
    wr(4, 32'h11111111);
    wr(5, 32'hFF);
    wait_idle("R5");
    check_frame("R4", 132);
    chk(nbits == 1056, "R3", "buffer order little-endian frame", nbits, 1056);
    rd(3, rv); chk(rv == 32'h5A, "R12", "write-byte held during busy", rv, 32'h5A);
    rd(5, rv); chk(rv == {24'h0, cur_addr[7:0]}, "R12", "address held during busy", rv, cur_addr[7:0]);

    nbits = 0;
    wr(0, 32'h10);
    rd(2, rv); chk(rv == 1, "R7", "pointer reset after completion", rv, 1);
    chk(nbits == 0, "R7", "no frame after completion restart", nbits, 0);
    wr(2, 1);

    // directed little-endian page, R3
    set_addr(32'h00ABCDEF);
    for (int w = 0; w < 32; w++) begin words[w] = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}; wr(4, words[w]); end
    hdr(cur_addr);
    for (int k = 0; k < 128; k++) expb[4 + k] = 8'(k);
    nbits = 0;
    wr(0, 32'h10);
    wr(1, 0);
    rd(1, rv); chk(rv == 1, "R2", "mode held while busy", rv, 1);
    wait_idle("R5");
    check_frame("R3", 132);
    @(negedge clk);
    rd(1, rv); chk(rv == 0, "R2", "mode applied after frame", rv, 0);

    set_addr(32'h00FFFFFE);
    pio_byte(8'h3C, "R9");
    pio_byte(8'hC3, "R9");
    rd(8, rv); chk(rv == 32'h01, "R9", "address carry into top byte", rv, 1);
    rd(5, rv); chk(rv == 32'h00, "R9", "address low byte after carry", rv, 0);
    for (int i = 0; i < 4; i++) pio_byte(8'($urandom), "R9");

    chk(mviol == 0, "R11", "mosi hold / sck idle violations", mviol, 0);
    chk(pviol == 0, "R11", "sck period violations", pviol, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  end
endmodule